// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces, one per clock, the column addresses that a synchronous DRAM visits during a single read or write burst. A controller pulses `start_i` together with the starting column, the 3-bit length code, the ordering select and the read/write direction. The block then walks the burst, flagging every beat with `beat_valid_o` and the final beat with `beat_last_o`. The length and ordering are captured at start, so the controller may change those inputs freely afterwards. Moving data is left to the surrounding logic.

Finite bursts stay inside an aligned group of columns the size of the burst. In linear order the low bits count upward and wrap. In swizzled order the low bits are the starting offset XORed with the beat number. A whole-row burst walks the row linearly, wraps at the top column and runs until `term_i` stops it. A single-write override turns every write into a one-beat access and leaves reads alone. Illegal settings raise `cfg_err_o` and produce no beats.

The controller has three states. `ST_IDLE` waits. `ST_BURST` emits beats. `ST_FAULT` lasts one cycle and reports a rejected start. The transitions are:
- start_ok: any state to `ST_BURST`.
- start_bad: any state to `ST_FAULT`.
- finish: `ST_BURST` to `ST_IDLE` on the final beat.
- stop: `ST_BURST` to `ST_IDLE` on terminate.
- fault_done: `ST_FAULT` to `ST_IDLE`.
- hold: `ST_IDLE` stays, or `ST_BURST` keeps counting.

A start always wins over every other transition.

Top module: `sdram_colseq`

## Requirements
- R1: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `beat_last_o` rises only on the final beat, and `beat_valid_o` is low on the cycle after it when no new start arrives.
- R2: With `interleave_i`=0, beat k of a finite burst of length L is (start & ~(L-1)) | ((start + k) mod L). For example, length 4 from column 1 gives 1,2,3,0.
- R3: With `interleave_i`=1, beat k is (start & ~(L-1)) | ((start mod L) XOR k). For example, length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: Code 3'b111 with `interleave_i`=0 is a whole-row burst. Beat k is (start + k) mod 2^COL_W, `beat_last_o` stays low, and the burst continues until terminated.
- R5: During a burst, a cycle with `term_i` high shows no beat and no last flag, and the block is idle from the next cycle.
- R6: When `wr_single_i`=1, a write (`is_write_i`=1) is one beat at the start column with `beat_last_o` high. A read still uses the programmed length and order.
- R7: When `wr_single_i`=0, a write uses the programmed length and order, exactly as a read does.
- R8: Codes 3'b100, 3'b101 and 3'b110 are reserved. A start with one of them raises `cfg_err_o` for exactly the next cycle and produces no beats.
- R9: Code 3'b111 with `interleave_i`=1 is rejected in the same way as R8, even for a write that R6 would shorten.
- R10: A start during a burst abandons that burst. The beat of the current cycle is still shown, and the new sequence begins on the next cycle.
- R11: Out of reset, `beat_valid_o`, `beat_last_o` and `cfg_err_o` are low.
- R12: The first beat appears in the cycle after the clock edge that samples `start_i`, and later beats follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst with the settings on the other inputs |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 = linear order, 1 = swizzled order |
| wr_single_i | input | 1 | Single-beat writes when 1 |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | This beat is the final one of a finite burst |
| cfg_err_o | output | 1 | The previous start was rejected |

## Verification
The bound checker watches protocol relations on every cycle:
- a last flag only ever comes with a beat;
- terminate and fault cycles never show a beat;
- a finite burst never stalls partway;
- nothing follows a final beat unless a new start arrives;
- every start is answered on the next cycle by a beat, a fault or a terminate.

The address values themselves can only be checked by the bench scenarios. These cover the linear and swizzled orderings, wrap at the block and row edges, the single-write override, restart partway through a burst, and the rejected codes.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_t;

    localparam logic [2:0] LEN_ROW = 3'b111;
endpackage

// File: rtl/colseq_len_dec.sv
module colseq_len_dec #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             wr_single_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_row_o,
    output logic             bad_o
);
    import colseq_pkg::*;

    logic       reserved;
    logic       row_code;
    logic       one_beat;
    logic [1:0] lg;

    always_comb begin
        row_code   = (len_code_i == LEN_ROW);
        reserved   = len_code_i[2] && !row_code;
        one_beat   = wr_single_i && is_write_i;
        bad_o      = reserved || (row_code && interleave_i);
        full_row_o = row_code && !one_beat;
        lg         = (one_beat || len_code_i[2]) ? 2'd0 : len_code_i[1:0];
    end

    // Each mask bit is set when it lies below the burst size (or whole row).
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = full_row_o | (int'(lg) > i);
    end
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] upper;
    logic [COL_W-1:0] lin_off;
    logic [COL_W-1:0] swz_off;

    always_comb begin
        upper   = start_col_i & ~mask_i;
        lin_off = (start_col_i + beat_i) & mask_i;
        swz_off = (start_col_i ^ beat_i) & mask_i;
        col_o   = upper | (interleave_i ? swz_off : lin_off);
    end
endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             wr_single_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             beat_last_o,
    output logic             cfg_err_o
);
    import colseq_pkg::*;

    seq_state_t       state_q, state_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] col0_q, col0_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             swz_q, swz_d;
    logic             row_q, row_d;

    logic [COL_W-1:0] dec_mask;
    logic             dec_row;
    logic             dec_bad;
    logic             final_beat;

    colseq_len_dec #(.COL_W(COL_W)) u_dec (
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .is_write_i   (is_write_i),
        .wr_single_i  (wr_single_i),
        .mask_o       (dec_mask),
        .full_row_o   (dec_row),
        .bad_o        (dec_bad)
    );

    colseq_addr_gen #(.COL_W(COL_W)) u_addr (
        .start_col_i  (col0_q),
        .mask_i       (mask_q),
        .beat_i       (beat_q),
        .interleave_i (swz_q),
        .col_o        (col_o)
    );

    assign final_beat = !row_q && (beat_q == mask_q);

    // Next-state process
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        col0_d  = col0_q;
        mask_d  = mask_q;
        swz_d   = swz_q;
        row_d   = row_q;
        if (start_i) begin
            // start_ok / start_bad
            col0_d  = start_col_i;
            mask_d  = dec_mask;
            swz_d   = interleave_i;
            row_d   = dec_row;
            beat_d  = '0;
            state_d = dec_bad ? ST_FAULT : ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: begin
                    if (term_i || final_beat) begin
                        state_d = ST_IDLE;
                    end else begin
                        beat_d = beat_q + 1'b1;
                    end
                end
                ST_FAULT: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            col0_q  <= '0;
            mask_q  <= '0;
            swz_q   <= 1'b0;
            row_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            col0_q  <= col0_d;
            mask_q  <= mask_d;
            swz_q   <= swz_d;
            row_q   <= row_d;
        end
    end

    // Output process
    always_comb begin
        beat_valid_o = 1'b0;
        beat_last_o  = 1'b0;
        cfg_err_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                beat_valid_o = !term_i;
                beat_last_o  = !term_i && final_beat;
            end
            ST_FAULT: cfg_err_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/colseq_chk.sv
module colseq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic term_i,
    input logic beat_valid_o,
    input logic beat_last_o,
    input logic cfg_err_o
);
    // R1
    last_has_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_valid_o);

    // R5
    term_hides_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_i |-> !beat_valid_o);

    // R8
    fault_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !beat_valid_o);

    // R1
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last_o && !start_i) |=> !beat_valid_o);

    // R12
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_last_o && !start_i) |=> (beat_valid_o || term_i));

    // R12
    start_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_valid_o || cfg_err_o || term_i));
endmodule

bind sdram_colseq colseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .term_i       (term_i),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o),
    .cfg_err_o    (cfg_err_o)
);

// File: tb/sdram_colseq_bench.sv
`timescale 1ns/1ps
module sdram_colseq_bench;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             is_write_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = 3'b000;
    logic             interleave_i = 1'b0;
    logic             wr_single_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_valid_o;
    logic             beat_last_o;
    logic             cfg_err_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sdram_colseq #(.COL_W(COL_W)) u_sdram_colseq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
        .start_col_i(start_col_i), .len_code_i(len_code_i),
        .interleave_i(interleave_i), .wr_single_i(wr_single_i), .term_i(term_i),
        .col_o(col_o), .beat_valid_o(beat_valid_o), .beat_last_o(beat_last_o),
        .cfg_err_o(cfg_err_o)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int c, int n, bit swz, int k);
        int m = n - 1;
        int up = c & ~m & ((1 << COL_W) - 1);
        if (swz) return up | ((c ^ k) & m);
        return up | ((c + k) & m);
    endfunction

    task automatic issue(int c, logic [2:0] code, bit swz, bit wr, bit ws);
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(c); len_code_i = code;
        interleave_i = swz; is_write_i = wr; wr_single_i = ws;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    // Runs one burst and checks n beats then idle.
    task automatic run_burst(string req, int c, logic [2:0] code, bit swz,
                             bit wr, bit ws, int n);
        issue(c, code, swz, wr, ws);
        for (int k = 0; k < n; k++) begin
            check({req, " valid"}, int'(beat_valid_o), 1);
            check({req, " col"}, int'(col_o), exp_col(c, n, swz, k));
            check({req, " last"}, int'(beat_last_o), (k == n - 1) ? 1 : 0);
            @(negedge clk); #1;
        end
        check({req, " idle after"}, int'(beat_valid_o), 0);
    endtask

    task automatic t_reset();
        check("R11 valid", int'(beat_valid_o), 0);
        check("R11 last", int'(beat_last_o), 0);
        check("R11 err", int'(cfg_err_o), 0);
    endtask

    task automatic t_full_row();
        issue(510, 3'b111, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            check("R4 valid", int'(beat_valid_o), 1);
            check("R4 col", int'(col_o), (510 + k) % 512);
            check("R4 no last", int'(beat_last_o), 0);
            @(negedge clk); #1;
        end
        term_i = 1'b1; #0.5;
        check("R5 term no beat", int'(beat_valid_o), 0);
        check("R5 term no last", int'(beat_last_o), 0);
        @(negedge clk); term_i = 1'b0; #1;
        check("R5 idle after term", int'(beat_valid_o), 0);
    endtask

    task automatic t_term_short();
        issue(0, 3'b011, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            check("R5 pre col", int'(col_o), k);
            @(negedge clk); #1;
        end
        term_i = 1'b1; #0.5;
        check("R5 valid", int'(beat_valid_o), 0);
        @(negedge clk); term_i = 1'b0; #1;
        check("R5 stays idle", int'(beat_valid_o), 0);
        @(negedge clk); #1;
        check("R5 stays idle 2", int'(beat_valid_o), 0);
    endtask

    task automatic t_restart();
        issue(3, 3'b011, 1'b0, 1'b0, 1'b0);
        check("R10 old b0", int'(col_o), 3);
        @(negedge clk); #1;
        check("R10 old b1", int'(col_o), 4);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd6; len_code_i = 3'b010;
        interleave_i = 1'b1; #1;
        check("R10 old beat shown", int'(col_o), 5);
        check("R10 old valid", int'(beat_valid_o), 1);
        @(negedge clk); start_i = 1'b0; #1;
        for (int k = 0; k < 4; k++) begin
            check("R10 new valid", int'(beat_valid_o), 1);
            check("R10 new col", int'(col_o), exp_col(6, 4, 1'b1, k));
            check("R10 new last", int'(beat_last_o), (k == 3) ? 1 : 0);
            @(negedge clk); #1;
        end
        check("R10 idle", int'(beat_valid_o), 0);
    endtask

    task automatic t_reject(string req, logic [2:0] code, bit swz, bit wr, bit ws);
        issue(7, code, swz, wr, ws);
        check({req, " err"}, int'(cfg_err_o), 1);
        check({req, " no beat"}, int'(beat_valid_o), 0);
        @(negedge clk); #1;
        check({req, " err one cycle"}, int'(cfg_err_o), 0);
        check({req, " still no beat"}, int'(beat_valid_o), 0);
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        run_burst("R1 R2 R12 len1", 7, 3'b000, 1'b0, 1'b0, 1'b0, 1);
        run_burst("R1 R2 len2", 5, 3'b001, 1'b0, 1'b0, 1'b0, 2);
        run_burst("R1 R2 len4", 1, 3'b010, 1'b0, 1'b0, 1'b0, 4);
        run_burst("R1 R2 len8", 13, 3'b011, 1'b0, 1'b0, 1'b0, 8);
        run_burst("R3 swz8", 5, 3'b011, 1'b1, 1'b0, 1'b0, 8);
        run_burst("R3 swz4", 10, 3'b010, 1'b1, 1'b0, 1'b0, 4);
        run_burst("R6 single write", 13, 3'b011, 1'b0, 1'b1, 1'b1, 1);
        run_burst("R6 read keeps len", 9, 3'b010, 1'b1, 1'b0, 1'b1, 4);
        run_burst("R7 write full len", 13, 3'b011, 1'b0, 1'b1, 1'b0, 8);
        t_full_row();
        t_term_short();
        t_restart();
        t_reject("R8 code4", 3'b100, 1'b0, 1'b0, 1'b0);
        t_reject("R8 code6", 3'b110, 1'b0, 1'b0, 1'b0);
        t_reject("R9 row swz", 3'b111, 1'b1, 1'b0, 1'b0);
        t_reject("R9 row swz write", 3'b111, 1'b1, 1'b1, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule